// File: doc/BRIEF.md
# Misaligned Access Bytemask Splitter

This block sits between a load/store unit and a pair of interleaved 16-byte cache-line ports. It takes one memory request, a 48-bit byte address with an access length of 1, 2, 4 or 8 bytes, and expands the length and the byte offset within the line into a 24-byte span mask. The lower 16 bits of that span select bytes in the line that holds the start address. Any bits above them select bytes at the start of the next line.

Each request that fits inside one line yields a single line request. A request that crosses a line boundary yields two: a head request for the starting line and a tail request for the line after it. Address bit 4 picks which of two lanes a line request uses, so the head and the tail of one access always land in opposite lanes. Lengths that are not a power of two up to 8 raise an error flag and produce no line request. Outputs are registered, with one cycle of latency.

Top module: `lsu_byte_splitter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `err_o` and every lane output (valid, line, mask, tail) read zero.
- R2: The span mask is `((1 << req_len) - 1) << req_addr[3:0]`, 24 bits wide. The head request's `lnK_bmask` is span bits 15..0, with bit i enabling byte i of the line.
- R3: The head request carries line address `req_addr[47:4]` in lane `req_addr[4]`, with `lnK_tail` = 0. A valid lane's line address always has bit 0 equal to its lane number.
- R4: If span bits 23..16 are not all zero, the opposite lane carries a tail request. Its line address is the head line address + 1, its mask is `{8'h00, span[23:16]}`, and `lnK_tail` = 1.
- R5: If span bits 23..16 are all zero, the opposite lane is not valid, and its line and mask read zero.
- R6: A valid request whose `req_len` is not 1, 2, 4 or 8 sets `err_o` on the next cycle, and both lanes are then not valid.
- R7: A cycle with `req_vld` low gives, on the next cycle, `err_o` = 0 and both lanes not valid.
- R8: Outputs show the request sampled at the previous rising clock edge and last one cycle only. Counted over both lanes, the enabled bytes equal the request length.
- R9: The tail line address wraps modulo 2^44, so a crossing from line 0xFFFFFFFFFFF goes to line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_vld | input | 1 | Request present this cycle |
| req_addr | input | 48 | Byte address of the access |
| req_len | input | 4 | Access length in bytes |
| err_o | output | 1 | Previous request had an illegal length |
| ln0_vld | output | 1 | Lane 0 holds a line request |
| ln0_line | output | 44 | Lane 0 line address (even lines) |
| ln0_bmask | output | 16 | Lane 0 byte enables |
| ln0_tail | output | 1 | Lane 0 request is the crossing tail |
| ln1_vld | output | 1 | Lane 1 holds a line request |
| ln1_line | output | 44 | Lane 1 line address (odd lines) |
| ln1_bmask | output | 16 | Lane 1 byte enables |
| ln1_tail | output | 1 | Lane 1 request is the crossing tail |

## Verification
The byte-count assertion assumes the length that produced the current outputs was legal. The lane-pair assertions assume a line can spill only into the line right after it, which holds only while the largest length does not exceed the line size. The stimulus keeps to these assumptions. Every illegal length is sent with `req_vld` high, so it takes the error path and never reaches the lanes. Crossing cases use offsets 14 and 15 with lengths 2, 4 and 8, and one case starts at the top address so the tail wraps.

// File: rtl/lsu_byte_splitter.sv
module lsu_byte_splitter #(
  parameter int ADDR_W     = 48,
  parameter int LINE_BYTES = 16,
  parameter int MAX_LEN    = 8,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              err_o,
  output logic              ln0_vld,
  output logic [LINE_W-1:0] ln0_line,
  output logic [LINE_BYTES-1:0] ln0_bmask,
  output logic              ln0_tail,
  output logic              ln1_vld,
  output logic [LINE_W-1:0] ln1_line,
  output logic [LINE_BYTES-1:0] ln1_bmask,
  output logic              ln1_tail
);
  localparam int SPAN_W = LINE_BYTES + MAX_LEN;

  logic                  len_ok;
  logic [SPAN_W-1:0]     span;
  logic [MAX_LEN-1:0]    spill_bits;
  logic                  spill;
  logic [LINE_W-1:0]     head_line;
  logic [LINE_W-1:0]     next_line;
  logic                  head_lane;

  assign len_ok = (req_len != '0) && ((req_len & (req_len - LEN_W'(1))) == '0)
                  && (int'(req_len) <= MAX_LEN);
  assign span = ((SPAN_W'(1) << req_len) - SPAN_W'(1)) << req_addr[OFF_W-1:0];
  assign spill_bits = span[SPAN_W-1:LINE_BYTES];
  assign spill = |spill_bits;
  assign head_line = req_addr[ADDR_W-1:OFF_W];
  assign next_line = head_line + LINE_W'(1);
  assign head_lane = req_addr[OFF_W];

  logic                  q_vld  [2];
  logic [LINE_W-1:0]     q_line [2];
  logic [LINE_BYTES-1:0] q_mask [2];
  logic                  q_tail [2];

  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic                  is_head;
    logic                  d_vld;
    assign is_head = (head_lane == 1'(k));
    assign d_vld   = req_vld && len_ok && (is_head || spill);

    always_ff @(posedge clk) begin
      if (!rst_n || !d_vld) begin
        q_vld[k]  <= 1'b0;
        q_line[k] <= '0;
        q_mask[k] <= '0;
        q_tail[k] <= 1'b0;
      end else begin
        q_vld[k]  <= 1'b1;
        q_line[k] <= is_head ? head_line : next_line;
        q_mask[k] <= is_head ? span[LINE_BYTES-1:0]
                             : {{(LINE_BYTES-MAX_LEN){1'b0}}, spill_bits};
        q_tail[k] <= !is_head;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= req_vld && !len_ok;
  end

  assign ln0_vld   = q_vld[0];
  assign ln0_line  = q_line[0];
  assign ln0_bmask = q_mask[0];
  assign ln0_tail  = q_tail[0];
  assign ln1_vld   = q_vld[1];
  assign ln1_line  = q_line[1];
  assign ln1_bmask = q_mask[1];
  assign ln1_tail  = q_tail[1];

  AST_LANE0_EVEN: assert property (@(posedge clk) disable iff (!rst_n) ln0_vld |-> !ln0_line[0]); // R3
  AST_LANE1_ODD: assert property (@(posedge clk) disable iff (!rst_n) ln1_vld |-> ln1_line[0]); // R3
  AST_TAIL1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (ln1_vld && ln1_tail) |-> (ln0_vld && !ln0_tail && ln1_line == ln0_line + LINE_W'(1))); // R4
  AST_TAIL0_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (ln0_vld && ln0_tail) |-> (ln1_vld && !ln1_tail && ln0_line == ln1_line + LINE_W'(1))); // R4
  AST_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n) (ln0_vld && ln0_tail) |-> !ln0_bmask[LINE_BYTES-1]); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (ln0_vld == 1'b0 && ln1_vld == 1'b0) |-> (ln0_bmask == '0 && ln1_bmask == '0)); // R5
  AST_ERR_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n) err_o |-> (!ln0_vld && !ln1_vld)); // R6
  AST_NO_REQ_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n) !req_vld |=> (!err_o && !ln0_vld && !ln1_vld)); // R7
  AST_BYTE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n) (ln0_vld || ln1_vld) |-> ($countones(ln0_bmask) + $countones(ln1_bmask) == int'($past(req_len)))); // R8
endmodule

// File: tb/test_lsu_byte_splitter.sv
module test_lsu_byte_splitter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [47:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic        err_o;
  logic        ln0_vld, ln0_tail, ln1_vld, ln1_tail;
  logic [43:0] ln0_line, ln1_line;
  logic [15:0] ln0_bmask, ln1_bmask;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  lsu_byte_splitter i_lsu_byte_splitter (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr), .req_len(req_len),
    .err_o(err_o),
    .ln0_vld(ln0_vld), .ln0_line(ln0_line), .ln0_bmask(ln0_bmask), .ln0_tail(ln0_tail),
    .ln1_vld(ln1_vld), .ln1_line(ln1_line), .ln1_bmask(ln1_bmask), .ln1_tail(ln1_tail)
  );

  // {addr, len, expected 24-bit span, expected error}
  localparam logic [76:0] VEC [12] = '{
    {48'h0000_0000_1000, 4'd4, 24'h00000F, 1'b0},
    {48'h0000_0000_1013, 4'd2, 24'h000018, 1'b0},
    {48'h0000_0000_100E, 4'd4, 24'h03C000, 1'b0},
    {48'h0000_0000_101F, 4'd8, 24'h7F8000, 1'b0},
    {48'h0000_0000_2008, 4'd8, 24'h00FF00, 1'b0},
    {48'h0000_0000_200F, 4'd1, 24'h008000, 1'b0},
    {48'h0000_0000_0040, 4'd3, 24'h000000, 1'b1},
    {48'h0000_0000_0040, 4'd0, 24'h000000, 1'b1},
    {48'h0000_0000_0040, 4'd9, 24'h000000, 1'b1},
    {48'hFFFF_FFFF_FFFF, 4'd2, 24'h018000, 1'b0},
    {48'h1234_5678_9AB7, 4'd8, 24'h007F80, 1'b0},
    {48'h0000_0000_0050, 4'd15, 24'h000000, 1'b1}
  };

  function automatic logic [61:0] lane0();
    return {ln0_vld, ln0_line, ln0_bmask, ln0_tail};
  endfunction
  function automatic logic [61:0] lane1();
    return {ln1_vld, ln1_line, ln1_bmask, ln1_tail};
  endfunction

  task automatic chk(input string tag, input logic [61:0] act, input logic [61:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic v, input logic [47:0] a, input logic [3:0] l);
    @(negedge clk);
    req_vld = v; req_addr = a; req_len = l;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset lane0", lane0(), '0);
    chk("R1 reset lane1", lane1(), '0);
    chk("R1 reset err", 62'(err_o), '0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      logic [47:0] a;
      logic [3:0]  l;
      logic [23:0] m;
      logic        e;
      logic [61:0] ex [2];
      string       tg [2];
      {a, l, m, e} = VEC[i];
      send(1'b1, a, l);
      for (int k = 0; k < 2; k++) begin
        if (e) begin
          ex[k] = '0; tg[k] = "R6 lane";
        end else if (a[4] == 1'(k)) begin
          ex[k] = {1'b1, a[47:4], m[15:0], 1'b0}; tg[k] = "R2/R3 head lane";
        end else if (m[23:16] != 8'h00) begin
          ex[k] = {1'b1, a[47:4] + 44'd1, 8'h00, m[23:16], 1'b1};
          tg[k] = (a[47:4] == '1) ? "R9 wrap tail lane" : "R4 tail lane";
        end else begin
          ex[k] = '0; tg[k] = "R5 idle lane";
        end
      end
      chk($sformatf("%s0 vec %0d", tg[0], i), lane0(), ex[0]);
      chk($sformatf("%s1 vec %0d", tg[1], i), lane1(), ex[1]);
      chk($sformatf("R6 err vec %0d", i), 62'(err_o), 62'(e));
    end

    // R7: valid low with an otherwise crossing request
    send(1'b0, 48'h0000_0000_100F, 4'd8);
    chk("R7 no req lane0", lane0(), '0);
    chk("R7 no req lane1", lane1(), '0);
    chk("R7 no req err", 62'(err_o), '0);

    // R8: one-cycle pulse, then gone
    send(1'b1, 48'h0000_0000_3000, 4'd1);
    chk("R8 pulse lane0", lane0(), {1'b1, 44'h300, 16'h0001, 1'b0});
    @(negedge clk); req_vld = 1'b0;
    @(negedge clk);
    chk("R8 hold lane0", lane0(), '0);

    // R1: reset overrides a live crossing request
    @(negedge clk); rst_n = 1'b0; req_vld = 1'b1; req_addr = 48'h0000_0000_101E; req_len = 4'd4;
    @(negedge clk);
    chk("R1 reset mid lane0", lane0(), '0);
    chk("R1 reset mid lane1", lane1(), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 after reset lane1", lane1(), {1'b1, 44'h101, 16'hC000, 1'b0});
    chk("R4 after reset lane0", lane0(), {1'b1, 44'h102, 16'h0003, 1'b1});
    req_vld = 1'b0;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule